// File: doc/BRIEF.md
# Conditional Three-Byte Branch Unit

This block executes one branch instruction made of three bytes taken in turn from a byte-wide fetch port. The first byte is the opcode, with the class prefix `11` in bits 7:6, the pair select in bit 5, four condition enables in bits 4:1 and a link enable in bit 0. The second byte is the target's upper half and the third byte its lower half. The block loads the 16-bit target into one of two register pairs, called M and J here. It then decides from the ALU's sign, carry and zero flags whether to load the program counter with that target.

A branch can be conditional on any mix of flag tests. With the link bit set, a taken branch saves the return address in the XY link register, so the same opcode also serves as a call. The unit owns the program counter. The PC is the fetch address, and it steps once for every byte accepted.

Top module: `goto_unit`

## Requirements
- R1: After synchronous active-low reset, `pc` is 0, `pc_load` is 0, `m_pair`, `j_pair` and `xy` are 0, and `byte_req` is 1.
- R2: A byte is accepted only in a cycle where `byte_req` and `byte_vld` are both high. While `byte_req` is high and `byte_vld` is low, the PC and the fetch position hold.
- R3: Every accepted byte advances `pc` by one at the same clock edge.
- R4: An opcode byte whose bits 7:6 are not `11` is consumed as a single byte. It causes no operand fetch, no register write and no `pc_load`.
- R5: Opcode bit 5 picks the destination pair: 0 selects `m_pair` and 1 selects `j_pair`. The second byte goes to bits 15:8 and the third byte to bits 7:0. The pair is written whether or not the branch is taken.
- R6: The condition enables are ORed together. Bit 4 passes on sign set, bit 3 on carry set, bit 2 on zero set, and bit 1 on zero clear.
- R7: When opcode bits 4:1 are all 0, the branch is always taken.
- R8: A taken branch sets `pc` to the 16-bit target and raises `pc_load` for exactly one cycle at the edge that ends the execute cycle. A branch that is not taken leaves `pc` at the address after the instruction, with no `pc_load` pulse.
- R9: When opcode bit 0 is set and the branch is taken, `xy` receives the address of the byte following the instruction. In every other case `xy` is unchanged.
- R10: The flags are sampled only in the execute cycle that follows the third byte. `byte_req` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | Fetch data valid |
| byte_data | input | 8 | Fetched instruction byte |
| byte_req | output | 1 | Unit is ready to take a byte |
| flag_sign | input | 1 | ALU result negative |
| flag_carry | input | 1 | ALU carry out |
| flag_zero | input | 1 | ALU result zero |
| pc | output | 16 | Program counter / fetch address |
| pc_load | output | 1 | One-cycle pulse when a branch reloads the PC |
| m_pair | output | 16 | M register pair |
| j_pair | output | 16 | J register pair |
| xy | output | 16 | Link register |

## Verification
The embedded assertions check on every cycle that an accepted byte steps the PC by one and that a stall freezes both the PC and the fetch state. They also check that a `pc_load` pulse only ever follows an execute cycle, that the pairs change only on an operand write to the selected pair, and that `xy` changes only together with a linked taken branch. Other behaviours need the bench scenarios: the OR of the condition tests, the unconditional case, the routing of the target bytes, the exact value saved in `xy`, the skipping of foreign opcodes, and flags that are sampled late rather than at opcode time. The bench shows the last one by driving inverted flags during the fetch bytes.

// File: rtl/goto_pkg.sv
// Shared types for the branch unit.
// Assumes a byte-wide fetch port and a 16-bit address made of two bytes.
package goto_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ST_OPC  = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2,
        ST_EXEC = 2'd3
    } gstate_t;

    // Opcode layout; bit positions are fixed by the instruction encoding.
    typedef struct packed {
        logic [1:0] cls;      // class prefix, 2'b11 for a branch
        logic       dsel;     // 0: M pair, 1: J pair
        logic       on_sign;  // pass if sign set
        logic       on_carry; // pass if carry set
        logic       on_zero;  // pass if zero set
        logic       on_nzero; // pass if zero clear
        logic       link;     // save return address in XY
    } gop_t;

    localparam logic [1:0] CLS_BRANCH = 2'b11;
endpackage

// File: rtl/goto_fetch_fsm.sv
// Fetch sequencer: steps OPC -> HI -> LO -> EXEC and holds the opcode and target.
// Assumes the fetch side presents a byte with byte_vld and that the byte is
// consumed at the edge where byte_req and byte_vld are both high.
module goto_fetch_fsm
    import goto_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output gstate_t           state,
    output logic              byte_req,
    output logic              accept,
    output gop_t              opc,
    output logic              pair_wr,
    output logic [ADDR_W-1:0] pair_data,
    output logic [ADDR_W-1:0] target
);
    gstate_t           state_q;
    gop_t              opc_q;
    logic [BYTE_W-1:0] hi_q;
    logic [BYTE_W-1:0] lo_q;

    // Handshake and operand-write strobes derived from the current state.
    always_comb begin
        byte_req  = (state_q != ST_EXEC);
        accept    = byte_req && byte_vld;
        pair_wr   = accept && (state_q == ST_LO);
        pair_data = {hi_q, byte_data};
        target    = {hi_q, lo_q};
        state     = state_q;
        opc       = opc_q;
    end

    // Sequencer state and byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPC;
            opc_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            case (state_q)
                ST_OPC: if (byte_vld) begin
                    opc_q <= gop_t'(byte_data);
                    if (byte_data[7:6] == CLS_BRANCH) state_q <= ST_HI;
                end
                ST_HI: if (byte_vld) begin
                    hi_q    <= byte_data;
                    state_q <= ST_LO;
                end
                ST_LO: if (byte_vld) begin
                    lo_q    <= byte_data;
                    state_q <= ST_EXEC;
                end
                default: state_q <= ST_OPC;
            endcase
        end
    end

    // R2: a stalled fetch keeps its position
    p_stall_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && !byte_vld) |=> $stable(state_q));
    // R10: the execute cycle lasts one cycle and returns to opcode fetch
    p_exec_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC) |=> (state_q == ST_OPC));
endmodule

// File: rtl/goto_cond_eval.sv
// Branch decision: ORs the enabled flag tests; no enables means always taken.
// Purely combinational, and only meaningful in the execute cycle.
module goto_cond_eval
    import goto_pkg::*;
(
    input  logic [1:0] cls,
    input  logic [3:0] cond_en,   // {sign, carry, zero, not-zero}
    input  logic       link_en,
    input  logic       flag_sign,
    input  logic       flag_carry,
    input  logic       flag_zero,
    output logic       taken,
    output logic       do_link
);
    logic [3:0] hits;

    // Evaluate each enabled test and combine them.
    always_comb begin
        hits    = cond_en & {flag_sign, flag_carry, flag_zero, !flag_zero};
        taken   = (cls == CLS_BRANCH) && ((cond_en == 4'b0000) || (hits != 4'b0000));
        do_link = taken && link_en;
    end
endmodule

// File: rtl/goto_regfile.sv
// Holds the M and J target pairs and the XY link register.
// Assumes at most one pair write per cycle, selected by wr_sel.
module goto_regfile
    import goto_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              link_en,
    input  logic [ADDR_W-1:0] link_data,
    output logic [ADDR_W-1:0] m_pair,
    output logic [ADDR_W-1:0] j_pair,
    output logic [ADDR_W-1:0] xy
);
    logic [ADDR_W-1:0] pair_q [2];
    logic [ADDR_W-1:0] xy_q;

    // One register per pair, written only when addressed.
    for (genvar g = 0; g < 2; g++) begin : g_pair
        always_ff @(posedge clk) begin
            if (!rst_n)                              pair_q[g] <= '0;
            else if (wr_en && (wr_sel == g[0]))      pair_q[g] <= wr_data;
        end
    end

    // Link register captures the return address on a linked taken branch.
    always_ff @(posedge clk) begin
        if (!rst_n)       xy_q <= '0;
        else if (link_en) xy_q <= link_data;
    end

    assign m_pair = pair_q[0];
    assign j_pair = pair_q[1];
    assign xy     = xy_q;

    // R5: M changes only on an operand write aimed at M
    p_m_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pair_q[0]) |-> $past(wr_en && !wr_sel));
    // R5: J changes only on an operand write aimed at J
    p_j_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pair_q[1]) |-> $past(wr_en && wr_sel));
    // R9: XY changes only on a linked taken branch
    p_xy_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xy_q) |-> $past(link_en));
endmodule

// File: rtl/goto_unit.sv
// Top of the conditional three-byte branch unit. Owns the PC, which steps by
// one for every byte accepted and is reloaded from the target on a taken branch.
// Assumes flags are valid in the execute cycle.
module goto_unit
    import goto_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    output logic        byte_req,
    input  logic        flag_sign,
    input  logic        flag_carry,
    input  logic        flag_zero,
    output logic [15:0] pc,
    output logic        pc_load,
    output logic [15:0] m_pair,
    output logic [15:0] j_pair,
    output logic [15:0] xy
);
    gstate_t           state;
    gop_t              opc;
    logic              accept;
    logic              pair_wr;
    logic [ADDR_W-1:0] pair_data;
    logic [ADDR_W-1:0] target;
    logic              taken;
    logic              do_link;
    logic              in_exec;
    logic [ADDR_W-1:0] pc_q;
    logic              load_q;

    goto_fetch_fsm u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .state     (state),
        .byte_req  (byte_req),
        .accept    (accept),
        .opc       (opc),
        .pair_wr   (pair_wr),
        .pair_data (pair_data),
        .target    (target)
    );

    goto_cond_eval u_cond (
        .cls        (opc.cls),
        .cond_en    ({opc.on_sign, opc.on_carry, opc.on_zero, opc.on_nzero}),
        .link_en    (opc.link),
        .flag_sign  (flag_sign),
        .flag_carry (flag_carry),
        .flag_zero  (flag_zero),
        .taken      (taken),
        .do_link    (do_link)
    );

    assign in_exec = (state == ST_EXEC);

    goto_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (pair_wr),
        .wr_sel    (opc.dsel),
        .wr_data   (pair_data),
        .link_en   (in_exec && do_link),
        .link_data (pc_q),
        .m_pair    (m_pair),
        .j_pair    (j_pair),
        .xy        (xy)
    );

    // Program counter: step on accept, reload on a taken branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RESET_PC;
            load_q <= 1'b0;
        end else begin
            load_q <= in_exec && taken;
            if (accept)                pc_q <= pc_q + 1'b1;
            else if (in_exec && taken) pc_q <= target;
        end
    end

    assign pc      = pc_q;
    assign pc_load = load_q;

    // R3: each accepted byte steps the PC by one
    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && byte_vld) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));
    // R2: a stall freezes the PC
    p_pc_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && !byte_vld) |=> $stable(pc_q));
    // R8: a load pulse only follows an execute cycle
    p_load_after_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> $past(state == ST_EXEC));
    // R8: the load pulse lasts one cycle
    p_load_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |=> !load_q);
endmodule

// File: tb/tb_goto_unit.sv
// Scoreboard bench: the driver queues the expected state after each
// instruction, and the monitor compares it with the ports.
module tb_goto_unit;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [15:0] pc;
        logic        load;
        logic [15:0] m;
        logic [15:0] j;
        logic [15:0] xy;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_req;
    logic        flag_sign = 1'b0, flag_carry = 1'b0, flag_zero = 1'b0;
    logic [15:0] pc, m_pair, j_pair, xy;
    logic        pc_load;

    int n_chk = 0;
    int n_bad = 0;
    exp_t sb[$];
    logic [15:0] e_pc = 16'h0, e_m = 16'h0, e_j = 16'h0, e_xy = 16'h0;

    goto_unit dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .byte_req(byte_req), .flag_sign(flag_sign), .flag_carry(flag_carry),
        .flag_zero(flag_zero), .pc(pc), .pc_load(pc_load),
        .m_pair(m_pair), .j_pair(j_pair), .xy(xy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Monitor: compare queued expectations one cycle after the execute edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " R8 pc"},      pc,             e.pc);
            chk({e.tag, " R8 pc_load"}, {15'b0, pc_load}, {15'b0, e.load});
            chk({e.tag, " R5 m_pair"},  m_pair,         e.m);
            chk({e.tag, " R5 j_pair"},  j_pair,         e.j);
            chk({e.tag, " R9 xy"},      xy,             e.xy);
            chk({e.tag, " R2 byte_req"}, {15'b0, byte_req}, 16'h1);
        end
    end

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = b;
        @(posedge clk);
    endtask

    // Driver: runs one branch instruction and queues the expected outcome.
    task automatic run_goto(string tag, logic [7:0] op, logic [7:0] hi, logic [7:0] lo,
                            logic s, logic c, logic z, bit stall);
        logic [15:0] after;
        logic        tk;
        exp_t        e;
        after = e_pc + 16'd3;
        // R6 / R7: OR of the enabled tests; none enabled means taken
        tk = (op[4:1] == 4'b0) || (op[4] && s) || (op[3] && c) || (op[2] && z) || (op[1] && !z);
        // R10: wrong flags while fetching
        flag_sign = !s; flag_carry = !c; flag_zero = !z;
        send_byte(op);
        if (stall) begin
            repeat (3) begin
                @(negedge clk);
                byte_vld = 1'b0;
            end
            chk({tag, " R2 stall pc"}, pc, e_pc + 16'd1);
        end
        send_byte(hi);
        send_byte(lo);
        @(negedge clk);
        byte_vld = 1'b0;
        flag_sign = s; flag_carry = c; flag_zero = z;
        chk({tag, " R10 byte_req low in exec"}, {15'b0, byte_req}, 16'h0);
        @(posedge clk);
        if (op[5]) e_j = {hi, lo}; else e_m = {hi, lo};
        if (tk && op[0]) e_xy = after;
        e_pc = tk ? {hi, lo} : after;
        e.pc = e_pc; e.load = tk; e.m = e_m; e.j = e_j; e.xy = e_xy; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // R4: a byte outside the branch class is consumed alone
    task automatic run_skip(logic [7:0] b);
        send_byte(b);
        @(negedge clk);
        byte_vld = 1'b0;
        e_pc = e_pc + 16'd1;
        chk("R4 skip pc", pc, e_pc);
        chk("R4 skip pc_load", {15'b0, pc_load}, 16'h0);
        chk("R4 skip byte_req", {15'b0, byte_req}, 16'h1);
        chk("R4 skip m_pair", m_pair, e_m);
        chk("R4 skip j_pair", j_pair, e_j);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pc", pc, 16'h0);
        chk("R1 pc_load", {15'b0, pc_load}, 16'h0);
        chk("R1 byte_req", {15'b0, byte_req}, 16'h1);
        chk("R1 m_pair", m_pair, 16'h0);
        chk("R1 j_pair", j_pair, 16'h0);
        chk("R1 xy", xy, 16'h0);

        run_goto("R7 uncond M",       8'hC0, 8'h12, 8'h34, 0, 0, 0, 0);
        run_goto("R6 sign link J",    8'hF1, 8'hA0, 8'h10, 1, 0, 0, 0);
        run_goto("R6 sign miss",      8'hF1, 8'hBE, 8'hEF, 0, 0, 0, 0);
        run_goto("R6 carry hit",      8'hC8, 8'h40, 8'h00, 0, 1, 0, 0);
        run_goto("R2 zero miss stall",8'hC4, 8'h55, 8'h66, 1, 1, 0, 1);
        run_goto("R9 nzero link",     8'hC3, 8'h70, 8'h08, 0, 0, 0, 0);
        run_goto("R10 nzero late z",  8'hE2, 8'h01, 8'h02, 0, 0, 1, 0);
        run_goto("R6 zero or carry",  8'hCC, 8'h90, 8'h90, 0, 0, 1, 0);
        run_goto("R9 no link miss",   8'hF9, 8'h33, 8'h44, 0, 0, 1, 0);
        run_skip(8'h3F);
        run_skip(8'h80);
        run_goto("R7 uncond J link",  8'hE1, 8'hFF, 8'hFE, 1, 1, 1, 1);
        repeat (3) @(negedge clk);
        chk("R8 no extra pulse", {15'b0, pc_load}, 16'h0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule